// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block keeps a signed 64-bit accumulator and adds signed products to it. The accumulator is read back as two 32-bit halves. A caller drives the operands, picks the operation and the saturation mode, and pulses a strobe. The accumulator takes the new value on the next rising clock edge. A separate clear strobe empties the accumulator.

There are two operations. The long form multiplies two signed 32-bit operands. The word form multiplies the signed low 16 bits of each operand.

With saturation off, both forms add into the full 64 bits and wrap. With saturation on, the clamping depends on the operation:
- The long form clamps the result to a signed 48-bit range.
- The word form works on the low half only and clamps it to the signed 32-bit range. On overflow it marks the event by writing 1 into the high half.

Top module: `sat_mac_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, both accumulator halves read zero.
- R2: A `clear` pulse makes both halves zero at the next rising edge. `clear` wins over an `op_valid` asserted in the same cycle.
- R3: Each accepted operation updates the accumulator at the first rising edge after the strobe. With neither `op_valid` nor `clear` asserted, the accumulator holds its value whatever the other inputs do.
- R4: With `op_sel`=0 (long form) and `sat_mode`=0, the accumulator becomes (accumulator + signed a × signed b) modulo 2^64.
- R5: With `op_sel`=0 and `sat_mode`=1, the exact sum is limited to the range −2^47 … 2^47−1. Bits 63:47 of the result are therefore all equal.
- R6: With `op_sel`=0 and `sat_mode`=1, if the 64-bit signed addition overflows, the result is chosen by the sign of the prior accumulator:
  - −2^47 when the prior accumulator was negative;
  - 2^47−1 otherwise.
- R7: With `op_sel`=1 (word form), only bits 15:0 of each operand are used, each read as signed, giving a signed 32-bit product. Bits 31:16 of the operands have no effect.
- R8: With `op_sel`=1 and `sat_mode`=0, the sign-extended product is added to the full 64-bit accumulator, modulo 2^64.
- R9: With `op_sel`=1 and `sat_mode`=1, the product is added to the low half alone. When that signed 32-bit sum does not overflow, the high half is unchanged.
- R10: With `op_sel`=1 and `sat_mode`=1, if the 32-bit sum overflows:
  - the low half becomes 0x80000000 if its prior value was negative, and 0x7FFFFFFF otherwise;
  - the high half becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe, one operation per high cycle |
| op_sel | input | 1 | 0 = long form, 1 = word form |
| sat_mode | input | 1 | 1 selects clamped accumulation |
| clear | input | 1 | Zeroes the accumulator; wins over `op_valid` |
| opnd_a | input | 32 | First signed operand |
| opnd_b | input | 32 | Second signed operand |
| acc_hi | output | 32 | Accumulator bits 63:32 |
| acc_lo | output | 32 | Accumulator bits 31:0 |

## Verification
The hardest state to reach is an overflow of the 64-bit addition in long saturated mode. It needs an accumulator within about 2^62 of either signed limit. The 48-bit clamp keeps the accumulator far from those limits once saturation is on. The bench therefore first builds the accumulator up with wrapping long operations using extreme operands (products near ±2^62), then applies one saturated long operation of the same sign. Word-form overflow is reached by repeating near-maximal 16-bit products. Before that, a long operation preloads a distinctive high half, so it shows whether the high half is kept or replaced by 1. Random upper operand bits on every word-form operation cover the ignored bits.

// File: rtl/sat_mac_pkg.sv
package sat_mac_pkg;

  typedef enum logic {
    OP_LONG = 1'b0,
    OP_WORD = 1'b1
  } mac_op_e;

endpackage

// File: rtl/mac_mul.sv
// Signed W x W multiplier producing the full 2W-bit product.
module mac_mul #(
  parameter int W = 32
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  logic signed [2*W-1:0] prod_s;

  always_comb begin
    prod_s = $signed(a) * $signed(b);
  end

  assign p = prod_s;
endmodule

// File: rtl/mac_long_path.sv
// Next accumulator value for the long form, wrapping or clamped to SAT_W bits.
module mac_long_path #(
  parameter int ACC_W = 64,
  parameter int SAT_W = 48
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [ACC_W-1:0] prod,
  input  logic             sat,
  output logic [ACC_W-1:0] acc_next
);
  localparam int TOP_W = ACC_W - SAT_W + 1;
  localparam logic [ACC_W-1:0] SAT_MAX = {{TOP_W{1'b0}}, {(SAT_W-1){1'b1}}};
  localparam logic [ACC_W-1:0] SAT_MIN = {{TOP_W{1'b1}}, {(SAT_W-1){1'b0}}};

  logic [ACC_W-1:0] sum;
  logic [TOP_W-1:0] top_bits;
  logic             add_ovf;
  logic             in_range;

  always_comb begin
    sum      = acc + prod;
    add_ovf  = (acc[ACC_W-1] == prod[ACC_W-1]) && (sum[ACC_W-1] != acc[ACC_W-1]);
    top_bits = sum[ACC_W-1:SAT_W-1];
    in_range = (&top_bits) || (~|top_bits);
    if (!sat) begin
      acc_next = sum;
    end else if (add_ovf) begin
      acc_next = acc[ACC_W-1] ? SAT_MIN : SAT_MAX;
    end else if (in_range) begin
      acc_next = sum;
    end else begin
      acc_next = sum[ACC_W-1] ? SAT_MIN : SAT_MAX;
    end
  end
endmodule

// File: rtl/mac_word_path.sv
// Next accumulator value for the word form: full-width wrap, or low-half clamp.
module mac_word_path #(
  parameter int HALF_W = 32,
  parameter int PROD_W = 32
) (
  input  logic [2*HALF_W-1:0] acc,
  input  logic [PROD_W-1:0]   prod,
  input  logic                sat,
  output logic [2*HALF_W-1:0] acc_next
);
  localparam int ACC_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] LO_MAX = {1'b0, {(HALF_W-1){1'b1}}};
  localparam logic [HALF_W-1:0] LO_MIN = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [HALF_W-1:0] HI_MARK = HALF_W'(1);

  logic [ACC_W-1:0]  prod_full;
  logic [HALF_W-1:0] prod_half;
  logic [HALF_W-1:0] lo_sum;
  logic [HALF_W-1:0] acc_lo;
  logic [HALF_W-1:0] acc_hi;
  logic              lo_ovf;

  always_comb begin
    prod_full = ACC_W'($signed(prod));
    prod_half = HALF_W'($signed(prod));
    acc_lo    = acc[HALF_W-1:0];
    acc_hi    = acc[ACC_W-1:HALF_W];
    lo_sum    = acc_lo + prod_half;
    lo_ovf    = (acc_lo[HALF_W-1] == prod_half[HALF_W-1]) &&
                (lo_sum[HALF_W-1] != acc_lo[HALF_W-1]);
    if (!sat) begin
      acc_next = acc + prod_full;
    end else if (lo_ovf) begin
      acc_next = {HI_MARK, acc_lo[HALF_W-1] ? LO_MIN : LO_MAX};
    end else begin
      acc_next = {acc_hi, lo_sum};
    end
  end
endmodule

// File: rtl/sat_mac_unit.sv
module sat_mac_unit #(
  parameter int OPND_W = 32,
  parameter int WORD_W = 16,
  parameter int SAT_W  = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic              op_sel,
  input  logic              sat_mode,
  input  logic              clear,
  input  logic [OPND_W-1:0] opnd_a,
  input  logic [OPND_W-1:0] opnd_b,
  output logic [OPND_W-1:0] acc_hi,
  output logic [OPND_W-1:0] acc_lo
);
  import sat_mac_pkg::*;

  localparam int HALF_W = OPND_W;
  localparam int ACC_W  = 2 * OPND_W;
  localparam int WPRD_W = 2 * WORD_W;
  localparam int CHK_LO = SAT_W - 1 - HALF_W;

  logic [ACC_W-1:0]  acc_q;
  logic [ACC_W-1:0]  acc_d;
  logic              acc_en;
  logic [ACC_W-1:0]  long_prod;
  logic [WPRD_W-1:0] word_prod;
  logic [ACC_W-1:0]  long_next;
  logic [ACC_W-1:0]  word_next;
  mac_op_e           op_kind;

  assign op_kind = mac_op_e'(op_sel);

  mac_mul #(.W(OPND_W)) u_long_mul (
    .a (opnd_a),
    .b (opnd_b),
    .p (long_prod)
  );

  mac_mul #(.W(WORD_W)) u_word_mul (
    .a (opnd_a[WORD_W-1:0]),
    .b (opnd_b[WORD_W-1:0]),
    .p (word_prod)
  );

  mac_long_path #(.ACC_W(ACC_W), .SAT_W(SAT_W)) u_long_path (
    .acc      (acc_q),
    .prod     (long_prod),
    .sat      (sat_mode),
    .acc_next (long_next)
  );

  mac_word_path #(.HALF_W(HALF_W), .PROD_W(WPRD_W)) u_word_path (
    .acc      (acc_q),
    .prod     (word_prod),
    .sat      (sat_mode),
    .acc_next (word_next)
  );

  // Next-state selection; clear has priority over an operation.
  always_comb begin
    acc_en = clear | op_valid;
    if (clear) begin
      acc_d = '0;
    end else if (op_kind == OP_WORD) begin
      acc_d = word_next;
    end else begin
      acc_d = long_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_hi = acc_q[ACC_W-1:HALF_W];
  assign acc_lo = acc_q[HALF_W-1:0];

  // Assertions
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (acc_hi == '0 && acc_lo == '0));

  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_hi == '0 && acc_lo == '0));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !op_valid) |=> ($stable(acc_hi) && $stable(acc_lo)));

  p_long_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !clear && !op_sel && sat_mode) |=>
      ((&acc_hi[HALF_W-1:CHK_LO]) || (~|acc_hi[HALF_W-1:CHK_LO])));

  p_word_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !clear && op_sel && sat_mode) |=>
      (acc_hi == $past(acc_hi) || acc_hi == HALF_W'(1)));
endmodule

// File: tb/sat_mac_unit_test.sv
module sat_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid, op_sel, sat_mode, clear;
  logic [31:0] opnd_a, opnd_b;
  logic [31:0] acc_hi, acc_lo;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;
  logic [63:0] m_acc;

  always #10 clk = ~clk;

  sat_mac_unit uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .sat_mode(sat_mode), .clear(clear), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .acc_hi(acc_hi), .acc_lo(acc_lo)
  );

  task automatic check(string req, logic [63:0] exp);
    n_chk++;
    if ({acc_hi, acc_lo} !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, {acc_hi, acc_lo}, exp);
    end
  endtask

  // Reference model built from exact wide arithmetic.
  function automatic logic [63:0] model(logic [63:0] acc, bit word, bit sat,
                                        logic [31:0] a, logic [31:0] b);
    logic signed [127:0] p, s;
    logic signed [63:0]  lo_s;
    logic [63:0]         r;
    if (!word) begin
      p = 128'($signed(a)) * 128'($signed(b));
      s = 128'($signed(acc)) + p;
      if (!sat) r = s[63:0];
      else if (s > 128'sh7FFF_FFFF_FFFF_FFFF || s < -128'sh8000_0000_0000_0000)
        r = acc[63] ? 64'hFFFF_8000_0000_0000 : 64'h0000_7FFF_FFFF_FFFF;
      else if (s > 128'sh7FFF_FFFF_FFFF) r = 64'h0000_7FFF_FFFF_FFFF;
      else if (s < -128'sh8000_0000_0000) r = 64'hFFFF_8000_0000_0000;
      else r = s[63:0];
    end else begin
      p = 128'($signed(a[15:0])) * 128'($signed(b[15:0]));
      if (!sat) r = acc + p[63:0];
      else begin
        lo_s = 64'($signed(acc[31:0])) + p[63:0];
        if (lo_s > 64'sh7FFF_FFFF || lo_s < -64'sh8000_0000)
          r = {32'd1, acc[31] ? 32'h8000_0000 : 32'h7FFF_FFFF};
        else r = {acc[63:32], lo_s[31:0]};
      end
    end
    return r;
  endfunction

  // Drive one operation at a falling edge, check at the next falling edge.
  task automatic do_op(bit word, bit sat, logic [31:0] a, logic [31:0] b, string req);
    op_valid = 1'b1; op_sel = word; sat_mode = sat; opnd_a = a; opnd_b = b;
    m_acc = model(m_acc, word, sat, a, b);
    @(negedge clk);
    op_valid = 1'b0;
    check(req, m_acc);
  endtask

  task automatic do_clear(bit with_op);
    clear = 1'b1; op_valid = with_op; op_sel = 1'b0; opnd_a = 32'h7FFF_FFFF; opnd_b = 32'h7FFF_FFFF;
    m_acc = '0;
    @(negedge clk);
    clear = 1'b0; op_valid = 1'b0;
    check("R2", m_acc);
  endtask

  logic [31:0] corner [8];

  initial begin
    corner[0] = 32'h0;        corner[1] = 32'h1;        corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h7FFF_FFFF; corner[4] = 32'h8000_0000; corner[5] = 32'h0000_7FFF;
    corner[6] = 32'hFFFF_8000; corner[7] = 32'h1234_5678;
    rst_n = 1'b0; op_valid = 0; op_sel = 0; sat_mode = 0; clear = 0;
    opnd_a = 32'hDEAD_BEEF; opnd_b = 32'hCAFE_F00D; m_acc = '0;
    repeat (3) @(negedge clk);
    check("R1", 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 64'h0);

    // R4: long wrapping over all corner pairs
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        do_op(1'b0, 1'b0, corner[i], corner[j], "R4");

    // R3: idle with changing inputs
    for (int k = 0; k < 4; k++) begin
      opnd_a = $urandom; opnd_b = $urandom; op_sel = k[0]; sat_mode = k[1];
      @(negedge clk);
      check("R3", m_acc);
    end

    // R2: clear alone and clear against a simultaneous operation
    do_clear(1'b0);
    do_op(1'b0, 1'b0, 32'h0001_0000, 32'h0003_0000, "R4");
    do_clear(1'b1);

    // R6: positive 64-bit overflow under saturation
    do_op(1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000, "R4");
    do_op(1'b0, 1'b0, 32'h7FFF_FFFF, 32'h7FFF_FFFF, "R4");
    do_op(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R6");
    check("R6", 64'h0000_7FFF_FFFF_FFFF);
    // R6: negative 64-bit overflow under saturation
    do_clear(1'b0);
    do_op(1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
    do_op(1'b0, 1'b0, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
    do_op(1'b0, 1'b1, 32'h8000_0000, 32'h7FFF_FFFF, "R6");
    check("R6", 64'hFFFF_8000_0000_0000);

    // R5: long saturated corner sweep and random runs
    do_clear(1'b0);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        do_op(1'b0, 1'b1, corner[i], corner[j], "R5");
    for (int k = 0; k < 300; k++)
      do_op(1'b0, 1'b1, $urandom, $urandom, "R5");

    // R7/R8: word wrapping with random upper operand bits
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        do_op(1'b1, 1'b0, {16'($urandom), corner[i][15:0]},
              {16'($urandom), corner[j][15:0]}, "R7_R8");

    // R9: preload high half to 5, small saturated word ops keep it
    do_clear(1'b0);
    do_op(1'b0, 1'b0, 32'h0005_0000, 32'h0001_0000, "R4");
    for (int k = 0; k < 16; k++)
      do_op(1'b1, 1'b1, {16'($urandom), 16'($urandom)}, 32'hABCD_0003, "R9");
    check("R9", {32'd5, m_acc[31:0]});

    // R10: positive overflow of the low half
    for (int k = 0; k < 5; k++)
      do_op(1'b1, 1'b1, 32'h0000_7FFF, 32'hFFFF_7FFF, "R10");
    check("R10", 64'h0000_0001_7FFF_FFFF);
    // R10: negative overflow of the low half
    do_clear(1'b0);
    do_op(1'b0, 1'b0, 32'h0009_0000, 32'h0001_0000, "R4");
    for (int k = 0; k < 5; k++)
      do_op(1'b1, 1'b1, 32'h0000_8000, 32'h0000_7FFF, "R10");
    check("R10", 64'h0000_0001_8000_0000);

    // Mixed random traffic over every mode
    for (int k = 0; k < 2000; k++) begin
      if (k % 97 == 0) do_clear($urandom_range(0, 1));
      else do_op($urandom_range(0, 1), $urandom_range(0, 1), $urandom, $urandom, "R4_R10");
    end

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule